// File: doc/BRIEF.md
# Programmable Clock Divider with Phase-Shifted Copy

This block divides a fast input clock by an integer between 1 and 32 and produces two registered outputs. The main output is a square wave of the selected period. The second output is a copy of the main output that can be delayed by up to three whole input cycles, inverted and gated. All logic runs in the input clock domain.

Software writes two configuration words, and each word carries a key. The divide word must hold a fixed base value plus the wanted ratio; a word outside that range selects a safe fallback ratio. The phase word carries an 8-bit key; a wrong key puts the copy into its default state, which is enabled, unshifted and not inverted. Every rejected write raises a one-cycle bad-write pulse. A running flag reports that the counter is advancing. A new ratio does not cut the current output period short: the counter finishes its period and then takes the new ratio.

Top module: `phdiv_top`

## Requirements
- R1: A divide write whose word lies in 0xAA0..0xABF selects ratio N = word - 0xAA0 for 1..31 and N = 32 for word 0xAA0, and `clk_div_o` then repeats with a period of N input cycles.
- R2: A divide word outside 0xAA0..0xABF selects ratio 31 and is a rejected write.
- R3: During reset `running_o`, `clk_div_o`, `clk_phase_o` and `bad_write_o` are low and the ratio is 16. `running_o` is high from the first clock edge after reset is released and stays high.
- R4: For N > 1, `clk_div_o` is high for floor(N/2) cycles of each period and low for the rest. For N = 1 it stays high.
- R5: A ratio written during a period takes effect only after the counter wraps, so the period in progress keeps its old length.
- R6: The phase word holds shift in bits 1:0, invert in bit 2, enable in bit 3 and key in bits 11:4 (key 0xAA). When enabled and not inverted, `clk_phase_o` equals `clk_div_o` delayed by shift + 1 input cycles. The shift may be changed while the divider runs.
- R7: With invert set, `clk_phase_o` is the inverse of that delayed value, except at N = 1, where invert has no effect.
- R8: With enable clear, `clk_phase_o` is low.
- R9: A phase word with a key other than 0xAA is a rejected write and sets enable on, shift 0, invert off. That is also the state after reset.
- R10: A divide write that asks for N = 1 (word 0xAA1) while the applied shift is non-zero is a rejected write and selects ratio 31.
- R11: `bad_write_o` is high for exactly the one cycle after the clock edge that took a rejected write. Accepted writes do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Write strobe for the divide word |
| div_word | input | 12 | Keyed divide word (base 0xAA0 plus ratio) |
| phase_wr | input | 1 | Write strobe for the phase word |
| phase_word | input | 12 | Keyed phase word: shift, invert, enable, key |
| clk_div_o | output | 1 | Registered main divided output |
| clk_phase_o | output | 1 | Registered shifted, inverted or gated copy |
| running_o | output | 1 | Divider counter is advancing |
| bad_write_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The main output is measured at the reset ratio 16 and after writes that select an odd ratio (5), an even ratio (6), the ratio-32 encoding and the fallback 31. Together these separate correct period length from correct high time and expose off-by-one and halving errors. The copy is compared cycle by cycle against a delayed history of the main output for shifts 0 to 3, with invert on and off and with the shift changed on the fly, which distinguishes delay, invert and gating faults. Rejected writes are driven with a bad divide key, a value just past the key range, a bad phase key, and a divide-by-1 request made while the shift is non-zero. A mid-period ratio change checks that the period in progress keeps its old length.

// File: rtl/phdiv_pkg.sv
package phdiv_pkg;

  // Outcome of decoding a divide word
  typedef enum logic [1:0] {
    DEC_OK          = 2'd0,
    DEC_BAD_KEY     = 2'd1,
    DEC_DIV1_SHIFT  = 2'd2
  } dec_status_e;

endpackage

// File: rtl/phdiv_ratio_decode.sv
module phdiv_ratio_decode
  import phdiv_pkg::*;
#(
  parameter int                DIV_WORD_W  = 12,
  parameter int                RATIO_SEL_W = 5,
  parameter logic [DIV_WORD_W-1:0] DIV_KEY = 12'hAA0
) (
  input  logic [DIV_WORD_W-1:0]    word_i,
  input  logic                     shift_nz_i,
  output logic [RATIO_SEL_W:0]     ratio_o,
  output dec_status_e              status_o
);

  localparam int CNT_W    = RATIO_SEL_W + 1;
  localparam int MAX_RAT  = 2 ** RATIO_SEL_W;
  localparam int FALLBACK = MAX_RAT - 1;

  logic                   key_ok;
  logic [RATIO_SEL_W-1:0] sel;

  assign key_ok = (word_i[DIV_WORD_W-1:RATIO_SEL_W] == DIV_KEY[DIV_WORD_W-1:RATIO_SEL_W]);
  assign sel    = word_i[RATIO_SEL_W-1:0];

  always_comb begin
    ratio_o  = CNT_W'(FALLBACK);
    status_o = DEC_OK;
    if (!key_ok) begin
      status_o = DEC_BAD_KEY;
    end else if (sel == '0) begin
      ratio_o = CNT_W'(MAX_RAT);
    end else if ((sel == RATIO_SEL_W'(1)) && shift_nz_i) begin
      status_o = DEC_DIV1_SHIFT;
    end else begin
      ratio_o = {1'b0, sel};
    end
  end

endmodule

// File: rtl/phdiv_phase_decode.sv
module phdiv_phase_decode #(
  parameter int                 SHIFT_W     = 2,
  parameter int                 PHASE_KEY_W = 8,
  parameter logic [PHASE_KEY_W-1:0] PHASE_KEY = 8'hAA
) (
  input  logic [SHIFT_W+1+PHASE_KEY_W:0] word_i,
  output logic [SHIFT_W-1:0]             shift_o,
  output logic                           flip_o,
  output logic                           en_o,
  output logic                           bad_o
);

  localparam int WORD_W = SHIFT_W + 2 + PHASE_KEY_W;

  logic key_ok;
  assign key_ok = (word_i[WORD_W-1 -: PHASE_KEY_W] == PHASE_KEY);

  always_comb begin
    if (key_ok) begin
      shift_o = word_i[SHIFT_W-1:0];
      flip_o  = word_i[SHIFT_W];
      en_o    = word_i[SHIFT_W+1];
      bad_o   = 1'b0;
    end else begin
      shift_o = '0;
      flip_o  = 1'b0;
      en_o    = 1'b1;
      bad_o   = 1'b1;
    end
  end

endmodule

// File: rtl/phdiv_counter.sv
module phdiv_counter #(
  parameter int RATIO_SEL_W = 5,
  parameter int RESET_RATIO = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RATIO_SEL_W:0] pending_i,
  output logic [RATIO_SEL_W:0] active_o,
  output logic [RATIO_SEL_W:0] cnt_o,
  output logic                 div_o,
  output logic                 running_o
);

  localparam int CNT_W = RATIO_SEL_W + 1;

  logic [CNT_W-1:0] cnt_q, active_q;
  logic             div_q, run_q;
  logic             wrap, level;

  assign wrap  = (cnt_q == active_q - CNT_W'(1));
  assign level = (active_q == CNT_W'(1)) ? 1'b1 : (cnt_q < (active_q >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= CNT_W'(RESET_RATIO);
      div_q    <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        div_q <= level;
        if (wrap) begin
          cnt_q    <= '0;
          active_q <= pending_i;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign active_o  = active_q;
  assign cnt_o     = cnt_q;
  assign div_o     = div_q;
  assign running_o = run_q;

endmodule

// File: rtl/phdiv_phase_tap.sv
module phdiv_phase_tap #(
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               flip_i,
  input  logic               en_i,
  input  logic               ratio_one_i,
  output logic               phase_o
);

  localparam int MAX_SHIFT = (2 ** SHIFT_W) - 1;

  logic [MAX_SHIFT:0] tap;
  logic               phase_q;

  assign tap[0] = div_i;

  for (genvar k = 1; k <= MAX_SHIFT; k++) begin : g_delay
    always_ff @(posedge clk) begin
      if (!rst_n) tap[k] <= 1'b0;
      else        tap[k] <= tap[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= 1'b0;
    else if (en_i) phase_q <= tap[shift_i] ^ (flip_i & ~ratio_one_i);
    else           phase_q <= 1'b0;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/phdiv_top.sv
module phdiv_top
  import phdiv_pkg::*;
#(
  parameter int                    DIV_WORD_W  = 12,
  parameter int                    RATIO_SEL_W = 5,
  parameter logic [DIV_WORD_W-1:0] DIV_KEY     = 12'hAA0,
  parameter int                    RESET_RATIO = 16,
  parameter int                    SHIFT_W     = 2,
  parameter int                    PHASE_KEY_W = 8,
  parameter logic [PHASE_KEY_W-1:0] PHASE_KEY  = 8'hAA,
  localparam int                   CNT_W        = RATIO_SEL_W + 1,
  localparam int                   PHASE_WORD_W = SHIFT_W + 2 + PHASE_KEY_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    div_wr,
  input  logic [DIV_WORD_W-1:0]   div_word,
  input  logic                    phase_wr,
  input  logic [PHASE_WORD_W-1:0] phase_word,
  output logic                    clk_div_o,
  output logic                    clk_phase_o,
  output logic                    running_o,
  output logic                    bad_write_o
);

  // Configuration state
  logic [CNT_W-1:0]   pending_q;
  logic [SHIFT_W-1:0] shift_q;
  logic               flip_q, phase_en_q, bad_q;

  // Decoder outputs
  logic [CNT_W-1:0]   dec_ratio;
  dec_status_e        dec_status;
  logic [SHIFT_W-1:0] ph_shift;
  logic               ph_flip, ph_en, ph_bad;

  // Counter outputs
  logic [CNT_W-1:0]   active_ratio, cnt_w;
  logic               div_w;

  phdiv_ratio_decode #(
    .DIV_WORD_W (DIV_WORD_W),
    .RATIO_SEL_W(RATIO_SEL_W),
    .DIV_KEY    (DIV_KEY)
  ) u_rdec (
    .word_i    (div_word),
    .shift_nz_i(shift_q != '0),
    .ratio_o   (dec_ratio),
    .status_o  (dec_status)
  );

  phdiv_phase_decode #(
    .SHIFT_W    (SHIFT_W),
    .PHASE_KEY_W(PHASE_KEY_W),
    .PHASE_KEY  (PHASE_KEY)
  ) u_pdec (
    .word_i (phase_word),
    .shift_o(ph_shift),
    .flip_o (ph_flip),
    .en_o   (ph_en),
    .bad_o  (ph_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q  <= CNT_W'(RESET_RATIO);
      shift_q    <= '0;
      flip_q     <= 1'b0;
      phase_en_q <= 1'b1;
      bad_q      <= 1'b0;
    end else begin
      if (div_wr) pending_q <= dec_ratio;
      if (phase_wr) begin
        shift_q    <= ph_shift;
        flip_q     <= ph_flip;
        phase_en_q <= ph_en;
      end
      bad_q <= (div_wr && (dec_status != DEC_OK)) || (phase_wr && ph_bad);
    end
  end

  phdiv_counter #(
    .RATIO_SEL_W(RATIO_SEL_W),
    .RESET_RATIO(RESET_RATIO)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pending_i(pending_q),
    .active_o (active_ratio),
    .cnt_o    (cnt_w),
    .div_o    (div_w),
    .running_o(running_o)
  );

  phdiv_phase_tap #(
    .SHIFT_W(SHIFT_W)
  ) u_tap (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_i      (div_w),
    .shift_i    (shift_q),
    .flip_i     (flip_q),
    .en_i       (phase_en_q),
    .ratio_one_i(active_ratio == CNT_W'(1)),
    .phase_o    (clk_phase_o)
  );

  assign clk_div_o   = div_w;
  assign bad_write_o = bad_q;

endmodule

// File: rtl/phdiv_checker.sv
module phdiv_checker #(
  parameter int                    DIV_WORD_W  = 12,
  parameter int                    RATIO_SEL_W = 5,
  parameter logic [DIV_WORD_W-1:0] DIV_KEY     = 12'hAA0,
  parameter int                    SHIFT_W     = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   div_wr,
  input logic [DIV_WORD_W-1:0]  div_word,
  input logic                   phase_wr,
  input logic                   bad_write_o,
  input logic                   running_o,
  input logic                   clk_div_o,
  input logic                   clk_phase_o,
  input logic                   phase_en_q,
  input logic [SHIFT_W-1:0]     shift_q,
  input logic [RATIO_SEL_W:0]   cnt,
  input logic [RATIO_SEL_W:0]   active
);

  localparam int CNT_W   = RATIO_SEL_W + 1;
  localparam int MAX_RAT = 2 ** RATIO_SEL_W;

  // R3: once running, the flag never drops
  assert_running_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |=> running_o);

  // R1: the applied ratio always lies in the legal range
  assert_ratio_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active >= CNT_W'(1)) && (active <= CNT_W'(MAX_RAT)));

  // R5: the counter never passes the applied ratio
  assert_cnt_below_ratio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> (cnt < active));

  // R4: at ratio 1 the main output stays high
  assert_ratio1_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && (active == CNT_W'(1))) |=> clk_div_o);

  // R8: a gated copy is low
  assert_gated_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en_q |=> !clk_phase_o);

  // R11: a bad-write pulse always follows a write strobe
  assert_badwrite_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_write_o |-> $past(div_wr || phase_wr));

  // R10: divide-by-1 with a non-zero shift is rejected
  assert_div1_shift_rejected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr && (div_word == DIV_KEY + DIV_WORD_W'(1)) && (shift_q != '0)) |=> bad_write_o);

endmodule

bind phdiv_top phdiv_checker #(
  .DIV_WORD_W (DIV_WORD_W),
  .RATIO_SEL_W(RATIO_SEL_W),
  .DIV_KEY    (DIV_KEY),
  .SHIFT_W    (SHIFT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_wr     (div_wr),
  .div_word   (div_word),
  .phase_wr   (phase_wr),
  .bad_write_o(bad_write_o),
  .running_o  (running_o),
  .clk_div_o  (clk_div_o),
  .clk_phase_o(clk_phase_o),
  .phase_en_q (phase_en_q),
  .shift_q    (shift_q),
  .cnt        (cnt_w),
  .active     (active_ratio)
);

// File: tb/phdiv_top_test.sv
module phdiv_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_wr = 1'b0;
  logic [11:0] div_word = '0;
  logic        phase_wr = 1'b0;
  logic [11:0] phase_word = '0;
  logic        clk_div_o, clk_phase_o, running_o, bad_write_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phdiv_top uut (
    .clk(clk), .rst_n(rst_n),
    .div_wr(div_wr), .div_word(div_word),
    .phase_wr(phase_wr), .phase_word(phase_word),
    .clk_div_o(clk_div_o), .clk_phase_o(clk_phase_o),
    .running_o(running_o), .bad_write_o(bad_write_o)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_rise();
    logic prev;
    prev = clk_div_o;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (!prev && clk_div_o) return;
      prev = clk_div_o;
    end
    check(0, "R1", "no rising edge of main output", 0, 1);
  endtask

  // Measures one full period starting at a rising edge
  task automatic measure(int n_exp, string req);
    int p, h;
    logic prev;
    wait_rise();
    p = 1; h = 1; prev = 1'b1;
    for (int i = 0; i < 100; i++) begin
      tick();
      if (clk_div_o && !prev) break;
      p++;
      if (clk_div_o) h++;
      prev = clk_div_o;
    end
    check(p == n_exp, req, "period", p, n_exp);
    check(h == n_exp / 2, "R4", "high cycles", h, n_exp / 2);
  endtask

  task automatic write_div(logic [11:0] word, bit exp_bad, string req);
    div_wr = 1'b1; div_word = word;
    tick();
    div_wr = 1'b0;
    check(bad_write_o == exp_bad, req, "bad_write after divide write", bad_write_o, exp_bad);
    tick();
    check(bad_write_o == 1'b0, "R11", "bad_write one cycle only", bad_write_o, 0);
  endtask

  task automatic write_phase(logic [7:0] key, bit en, bit flip, logic [1:0] sh,
                             bit exp_bad, string req);
    phase_wr = 1'b1; phase_word = {key, en, flip, sh};
    tick();
    phase_wr = 1'b0;
    check(bad_write_o == exp_bad, req, "bad_write after phase write", bad_write_o, exp_bad);
    tick();
    check(bad_write_o == 1'b0, "R11", "bad_write one cycle only", bad_write_o, 0);
  endtask

  // Compares the copy against the delayed history of the main output
  task automatic check_phase(int sh, bit flip, bit en, bit ratio1, string req);
    logic hist [0:4];
    logic exp;
    int bad;
    for (int i = 0; i < 5; i++) begin
      for (int j = 4; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = clk_div_o;
      tick();
    end
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      exp = en ? (hist[sh] ^ (flip & !ratio1)) : 1'b0;
      if (clk_phase_o !== exp) bad++;
      for (int j = 4; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = clk_div_o;
      tick();
    end
    check(bad == 0, req, "phase mismatching cycles", bad, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(running_o == 0, "R3", "running in reset", running_o, 0);
    check(clk_div_o == 0, "R3", "main output in reset", clk_div_o, 0);
    check(clk_phase_o == 0, "R3", "copy in reset", clk_phase_o, 0);
    check(bad_write_o == 0, "R3", "bad_write in reset", bad_write_o, 0);
    rst_n = 1'b1;
    tick();
    check(running_o == 1, "R3", "running after release", running_o, 1);
    measure(16, "R3");
    check_phase(0, 0, 1, 0, "R9");
    check(running_o == 1, "R3", "running held", running_o, 1);
  endtask

  task automatic t_ratios();
    write_div(12'hAA5, 0, "R11"); wait_rise(); measure(5, "R1");
    write_div(12'hAA6, 0, "R11"); wait_rise(); measure(6, "R1");
    write_div(12'hAA0, 0, "R11"); wait_rise(); measure(32, "R1");
  endtask

  task automatic t_bad_div();
    write_div(12'h123, 1, "R2"); wait_rise(); measure(31, "R2");
    write_div(12'hAA3, 0, "R11"); wait_rise(); measure(3, "R1");
    write_div(12'hAC0, 1, "R2"); wait_rise(); measure(31, "R2");
  endtask

  task automatic t_change_at_wrap();
    int p;
    logic prev;
    write_div(12'hAA4, 0, "R11"); wait_rise(); wait_rise();
    p = 1;
    div_wr = 1'b1; div_word = 12'hAA8;
    tick(); p++;
    div_wr = 1'b0;
    prev = clk_div_o;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (clk_div_o && !prev) break;
      p++;
      prev = clk_div_o;
    end
    check(p == 4, "R5", "period in progress keeps old ratio", p, 4);
    measure(8, "R5");
  endtask

  task automatic t_phase();
    write_phase(8'hAA, 1, 0, 2'd2, 0, "R11"); check_phase(2, 0, 1, 0, "R6");
    write_phase(8'hAA, 1, 0, 2'd1, 0, "R11"); check_phase(1, 0, 1, 0, "R6");
    write_phase(8'hAA, 1, 1, 2'd3, 0, "R11"); check_phase(3, 1, 1, 0, "R7");
    write_phase(8'hAA, 0, 1, 2'd3, 0, "R11"); check_phase(3, 1, 0, 0, "R8");
    write_phase(8'h55, 0, 1, 2'd3, 1, "R9");  check_phase(0, 0, 1, 0, "R9");
  endtask

  task automatic t_div1();
    int low;
    write_phase(8'hAA, 1, 0, 2'd2, 0, "R11");
    write_div(12'hAA1, 1, "R10"); wait_rise(); measure(31, "R10");
    write_phase(8'hAA, 1, 1, 2'd0, 0, "R11");
    write_div(12'hAA1, 0, "R10");
    repeat (40) tick();
    low = 0;
    for (int i = 0; i < 20; i++) begin
      if (!clk_div_o) low++;
      tick();
    end
    check(low == 0, "R4", "ratio 1 low cycles", low, 0);
    check_phase(0, 1, 1, 1, "R7");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_bad_div();
    t_change_at_wrap();
    t_phase();
    t_div1();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

endmodule